// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting RAM with Background Scrubbing

This block wraps a single-port word memory so that every stored word carries Hamming check bits plus one extra parity bit over the whole codeword. A write encodes the data on the way in. A read recomputes the Hamming syndrome and the overall parity of the stored codeword, and then returns the data with two flags. One flag marks a single-bit error that was repaired. The other marks a double-bit error that could not be repaired. A double-bit error is never "repaired" into wrong data.

A background scrubber shares the memory port. On every cycle with no user request it walks the address space in order, one word at a time. It checks each word, and when it finds a correctable error it writes the repaired codeword back. This keeps a second upset from landing in a word that already has one. Words with double-bit errors are left in place and counted. User requests always win the port. A user write to the word the scrubber is in the middle of repairing cancels that repair, so fresh data is never overwritten by a stale copy.

Top module: `ecc_scrub_ram`

## Requirements
- R1: A read request sampled on a rising edge produces `rsp_valid` high for exactly one cycle after the second rising edge, carrying the stored data. `rsp_valid` is low after the first edge. A write request produces no response.
- R2: Codeword layout: bit 0 is the overall parity, check bit j sits at position 2^j, and data bit i sits at the (i+1)-th position, counting from 1, that is not a power of two. A single flipped data position is returned repaired, with `rsp_corrected`=1 and `rsp_uncorrectable`=0.
- R3: A single flipped Hamming check position (2^j) leaves the returned data intact and sets `rsp_corrected`.
- R4: A flip of only the overall parity bit (bit 0, syndrome zero) returns intact data and is reported as corrected.
- R5: Any two flipped positions set `rsp_uncorrectable`=1 and `rsp_corrected`=0. The data bits are returned exactly as stored, with no repair attempted.
- R6: `rsp_corrected` and `rsp_uncorrectable` are never high together, and neither is high without `rsp_valid`.
- R7: A user request is never delayed by the scrubber. Read latency and read data stay as in R1 under continuous traffic with errors injected.
- R8: During idle cycles the scrubber visits every address in ascending order with wrap-around, and writes back a repaired codeword for any correctable word. A single upset left alone is therefore gone after a full idle pass.
- R9: A double-error word met by the scrubber is left unchanged, and each visit adds one to `scrub_uncorr_cnt`, which saturates. Clean words do not change the count.
- R10: A user write to the address whose scrub repair is pending cancels that repair. The user data survives, and the scrubber re-reads that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read data (repaired when correctable) |
| rsp_corrected | output | 1 | Response had a single-bit error that was repaired |
| rsp_uncorrectable | output | 1 | Response had a double-bit error; data passed unrepaired |
| scrub_uncorr_cnt | output | CNT_W | Saturating count of double-error words met by the scrubber |

## Verification
The bench flips stored codeword bits directly and reads them back. It covers a flip in each data position class, in every check-bit position and in the lone parity bit, and random pairs that include the parity bit. A decoder that read the syndrome alone would miscorrect pairs into wrong data, and one that ignored a zero syndrome with bad parity would miss the parity-only upset. For the scrubber, the bench first leaves a single upset alone across a full idle pass and then adds a second upset. A scrubber that never writes back turns this into an uncorrectable read. The bench also places a user write exactly in the cycle where a repair is pending. A scrubber without the cancel path would later restore the old data over the new.

// File: rtl/ecc_scrub_pkg.sv
// Shared helpers for the protected RAM: check-bit sizing, the data-to-
// codeword position map, and the scrubber state type.
// Assumes: codeword position 0 holds overall parity, positions 1..N form a
// classic Hamming layout with check bits at the powers of two.
package ecc_scrub_pkg;

    // Smallest r such that 2^r >= data + r + 1.
    function automatic int chk_bits(input int dw);
        int r;
        r = 1;
        while ((1 << r) < dw + r + 1) r++;
        return r;
    endfunction

    // Codeword position of data bit idx: the (idx+1)-th non-power-of-two >= 3.
    function automatic int data_pos(input int idx);
        int p;
        int n;
        p = 2;
        n = -1;
        while (n < idx) begin
            p++;
            if ((p & (p - 1)) != 0) n++;
        end
        return p;
    endfunction

    typedef enum logic [1:0] {
        SCR_READ  = 2'd0,
        SCR_CHECK = 2'd1,
        SCR_WBACK = 2'd2
    } scrub_state_e;

endpackage

// File: rtl/ecc_encoder.sv
// Builds the stored codeword from a data word: places data bits at their
// Hamming positions, computes each check bit as the XOR of every position
// whose index has that bit set, then adds overall parity at bit 0.
// Assumes: purely combinational, one instance per write path.
module ecc_encoder #(
    parameter int DATA_W = 32,
    parameter int CHK_R  = ecc_scrub_pkg::chk_bits(DATA_W),
    parameter int CW_W   = DATA_W + CHK_R + 1
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CW_W-1:0]   cw_o
);
    import ecc_scrub_pkg::*;

    localparam int N = DATA_W + CHK_R;

    // Encode: data placement, Hamming check bits, overall parity.
    always_comb begin
        logic [CW_W-1:0] cw;
        logic            acc;
        cw = '0;
        for (int i = 0; i < DATA_W; i++) begin
            cw[data_pos(i)] = data_i[i];
        end
        for (int j = 0; j < CHK_R; j++) begin
            acc = 1'b0;
            for (int p = 1; p <= N; p++) begin
                if (((p >> j) & 1) == 1) acc = acc ^ cw[p];
            end
            cw[1 << j] = acc;
        end
        cw[0] = ^cw[N:1];
        cw_o  = cw;
    end

endmodule

// File: rtl/ecc_decoder.sv
// Checks a stored codeword: computes the Hamming syndrome and the overall
// parity, classifies the error from the pair, and produces the repaired
// codeword and data.
// Assumes: syndrome 0 with bad parity means the parity bit flipped; a bad
// parity with a syndrome past the last position is treated as uncorrectable.
module ecc_decoder #(
    parameter int DATA_W = 32,
    parameter int CHK_R  = ecc_scrub_pkg::chk_bits(DATA_W),
    parameter int CW_W   = DATA_W + CHK_R + 1
) (
    input  logic [CW_W-1:0]   cw_i,
    output logic [DATA_W-1:0] data_o,
    output logic [CW_W-1:0]   fixed_o,
    output logic              corr_o,
    output logic              uncorr_o
);
    import ecc_scrub_pkg::*;

    localparam int N = DATA_W + CHK_R;

    logic [CHK_R-1:0] syn;
    logic             perr;
    logic             in_range;

    // Syndrome: one XOR tree per check bit over the covered positions.
    always_comb begin
        logic acc;
        syn = '0;
        for (int j = 0; j < CHK_R; j++) begin
            acc = 1'b0;
            for (int p = 1; p <= N; p++) begin
                if (((p >> j) & 1) == 1) acc = acc ^ cw_i[p];
            end
            syn[j] = acc;
        end
    end

    // Overall parity across data, check bits and the parity bit itself.
    assign perr     = ^cw_i;
    assign in_range = (syn <= CHK_R'(N));

    // Classification from (syndrome, parity).
    assign corr_o   = perr && in_range;
    assign uncorr_o = (!perr && (syn != '0)) || (perr && !in_range);

    // Repair: flip the position named by the syndrome only when correctable.
    always_comb begin
        fixed_o = cw_i;
        if (corr_o) begin
            for (int p = 0; p <= N; p++) begin
                if (syn == CHK_R'(p)) fixed_o[p] = ~cw_i[p];
            end
        end
    end

    // Data extraction from the (possibly repaired) codeword.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            data_o[i] = fixed_o[data_pos(i)];
        end
    end

endmodule

// File: rtl/ecc_word_store.sv
// Single-port word array with a registered read port.
// Assumes: one access per cycle; contents are not reset.
module ecc_word_store #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int WORD_W = 39
) (
    input  logic              clk,
    input  logic              en_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Array access: write or registered read.
    always_ff @(posedge clk) begin
        if (en_i) begin
            if (we_i) mem[addr_i] <= wdata_i;
            else      rdata_o     <= mem[addr_i];
        end
    end

endmodule

// File: rtl/ecc_scrubber.sv
// Idle-time scrubber: reads the word at its pointer when the port is free,
// inspects the decode the following cycle, writes back a repaired codeword
// when the word was correctable, counts uncorrectable words, then advances.
// Assumes: the decoder inputs describe the word read by the previous
// scrub read while in SCR_CHECK; user requests always own the port.
module ecc_scrubber #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int CW_W   = 39,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              chk_corr_i,
    input  logic              chk_uncorr_i,
    input  logic [CW_W-1:0]   chk_fixed_i,
    output logic              scrub_rd_o,
    output logic              scrub_wr_o,
    output logic [ADDR_W-1:0] scrub_addr_o,
    output logic [CW_W-1:0]   scrub_wdata_o,
    output logic [CNT_W-1:0]  uncorr_cnt_o
);
    import ecc_scrub_pkg::*;

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0]  CNT_MAX   = '1;

    scrub_state_e      state_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] ptr_next;
    logic [CW_W-1:0]   fix_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              user_hit;

    // Next pointer with wrap at the last word.
    assign ptr_next = (ptr_q == LAST_ADDR) ? '0 : ptr_q + 1'b1;
    // A user write to the word under scrub invalidates any pending repair.
    assign user_hit = req_valid_i && req_write_i && (req_addr_i == ptr_q);

    // Port requests: only when no user request is present.
    assign scrub_rd_o    = (state_q == SCR_READ)  && !req_valid_i;
    assign scrub_wr_o    = (state_q == SCR_WBACK) && !req_valid_i;
    assign scrub_addr_o  = ptr_q;
    assign scrub_wdata_o = fix_q;
    assign uncorr_cnt_o  = cnt_q;

    // Scrub sequence: read, check, optional write-back, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SCR_READ;
            ptr_q   <= '0;
            fix_q   <= '0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                SCR_READ: begin
                    if (!req_valid_i) state_q <= SCR_CHECK;
                end
                SCR_CHECK: begin
                    if (user_hit) begin
                        state_q <= SCR_READ;
                    end else if (chk_corr_i) begin
                        fix_q   <= chk_fixed_i;
                        state_q <= SCR_WBACK;
                    end else begin
                        if (chk_uncorr_i && (cnt_q != CNT_MAX)) cnt_q <= cnt_q + 1'b1;
                        ptr_q   <= ptr_next;
                        state_q <= SCR_READ;
                    end
                end
                SCR_WBACK: begin
                    if (user_hit) begin
                        state_q <= SCR_READ;
                    end else if (!req_valid_i) begin
                        ptr_q   <= ptr_next;
                        state_q <= SCR_READ;
                    end
                end
                default: state_q <= SCR_READ;
            endcase
        end
    end

    // R10: a cancelled repair never reaches the port.
    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != SCR_READ) && user_hit) |=> !scrub_wr_o);

    // R8: the pointer only steps by one, wrapping after the last word.
    p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr_q) |-> (($past(ptr_q) == LAST_ADDR) ? (ptr_q == '0)
                                                         : (ptr_q == $past(ptr_q) + 1'b1)));

    // R8: a write-back is entered only after a correctable check.
    p_wb_needs_corr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == SCR_WBACK) && ($past(state_q) == SCR_CHECK)) |-> $past(chk_corr_i));

    // R9: the count moves by one and only after an uncorrectable check.
    p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_q) |-> ((cnt_q == $past(cnt_q) + 1'b1) && $past(chk_uncorr_i)));

endmodule

// File: rtl/ecc_scrub_ram.sv
// Top of the protected RAM: encodes user writes, decodes every read,
// registers user read responses with error flags, and lets the scrubber
// use the single memory port whenever no user request is present.
// Assumes: one request per cycle; read responses appear two edges after
// the request; DEPTH is at least 2.
module ecc_scrub_ram #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 8,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_corrected,
    output logic              rsp_uncorrectable,
    output logic [CNT_W-1:0]  scrub_uncorr_cnt
);
    import ecc_scrub_pkg::*;

    localparam int CHK_R = chk_bits(DATA_W);
    localparam int CW_W  = DATA_W + CHK_R + 1;

    logic [CW_W-1:0]   enc_cw;
    logic [CW_W-1:0]   rd_cw;
    logic [DATA_W-1:0] dec_data;
    logic [CW_W-1:0]   dec_fixed;
    logic              dec_corr;
    logic              dec_uncorr;
    logic              scrub_rd;
    logic              scrub_wr;
    logic [ADDR_W-1:0] scrub_addr;
    logic [CW_W-1:0]   scrub_wdata;
    logic              mem_en;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [CW_W-1:0]   mem_wdata;
    logic              rd_user_q;

    ecc_encoder #(.DATA_W(DATA_W), .CHK_R(CHK_R), .CW_W(CW_W)) u_enc (
        .data_i (req_wdata),
        .cw_o   (enc_cw)
    );

    // Port arbitration: the user request always wins.
    assign mem_en    = req_valid || scrub_rd || scrub_wr;
    assign mem_we    = req_valid ? req_write : scrub_wr;
    assign mem_addr  = req_valid ? req_addr  : scrub_addr;
    assign mem_wdata = req_valid ? enc_cw    : scrub_wdata;

    ecc_word_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .WORD_W(CW_W)) u_store (
        .clk     (clk),
        .en_i    (mem_en),
        .we_i    (mem_we),
        .addr_i  (mem_addr),
        .wdata_i (mem_wdata),
        .rdata_o (rd_cw)
    );

    ecc_decoder #(.DATA_W(DATA_W), .CHK_R(CHK_R), .CW_W(CW_W)) u_dec (
        .cw_i     (rd_cw),
        .data_o   (dec_data),
        .fixed_o  (dec_fixed),
        .corr_o   (dec_corr),
        .uncorr_o (dec_uncorr)
    );

    ecc_scrubber #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CW_W(CW_W), .CNT_W(CNT_W)) u_scrub (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid_i   (req_valid),
        .req_write_i   (req_write),
        .req_addr_i    (req_addr),
        .chk_corr_i    (dec_corr),
        .chk_uncorr_i  (dec_uncorr),
        .chk_fixed_i   (dec_fixed),
        .scrub_rd_o    (scrub_rd),
        .scrub_wr_o    (scrub_wr),
        .scrub_addr_o  (scrub_addr),
        .scrub_wdata_o (scrub_wdata),
        .uncorr_cnt_o  (scrub_uncorr_cnt)
    );

    // Read-in-flight marker for user reads.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_user_q <= 1'b0;
        else        rd_user_q <= req_valid && !req_write;
    end

    // Response register: data and flags from the decode of a user read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid         <= 1'b0;
            rsp_rdata         <= '0;
            rsp_corrected     <= 1'b0;
            rsp_uncorrectable <= 1'b0;
        end else begin
            rsp_valid         <= rd_user_q;
            rsp_corrected     <= rd_user_q && dec_corr;
            rsp_uncorrectable <= rd_user_q && dec_uncorr;
            if (rd_user_q) rsp_rdata <= dec_data;
        end
    end

    // R1, R7: every user read answers two edges later, whatever the scrubber does.
    p_read_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |-> ##2 rsp_valid);

    // R1: writes give no response.
    p_write_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |-> ##2 !rsp_valid);

    // R6: the two flags exclude each other.
    p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_corrected && rsp_uncorrectable));

    // R6: flags only accompany a valid response.
    p_flags_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_corrected || rsp_uncorrectable) |-> rsp_valid);

endmodule

// File: tb/sim_ecc_scrub_ram.sv
module sim_ecc_scrub_ram;
    localparam int  DATA_W   = 32;
    localparam int  DEPTH    = 16;
    localparam int  CNT_W    = 8;
    localparam int  ADDR_W   = $clog2(DEPTH);
    localparam time CLK_HALF = 5ns;

    function automatic int b_chk(input int dw);
        int r = 1;
        while ((2 ** r) < dw + r + 1) r = r + 1;
        return r;
    endfunction

    localparam int CHK = b_chk(DATA_W);
    localparam int NPOS = DATA_W + CHK;  // last Hamming position

    // Position of data bit i per R2.
    function automatic int b_pos(input int i);
        int cnt = 0;
        for (int p = 1; p <= 1024; p++) begin
            if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16 && p != 32 && p != 64
                && p != 128 && p != 256 && p != 512) begin
                if (cnt == i) return p;
                cnt = cnt + 1;
            end
        end
        return -1;
    endfunction

    // Data bit index held at a position, or -1 for parity/check positions.
    function automatic int b_idx(input int pos);
        for (int i = 0; i < DATA_W; i++) if (b_pos(i) == pos) return i;
        return -1;
    endfunction

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid;
    logic              req_write;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic              rsp_corrected;
    logic              rsp_uncorrectable;
    logic [CNT_W-1:0]  scrub_uncorr_cnt;

    int checks = 0;
    int fails  = 0;
    logic [DATA_W-1:0] model [DEPTH];

    always #(CLK_HALF) clk = ~clk;

    ecc_scrub_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_corrected(rsp_corrected),
        .rsp_uncorrectable(rsp_uncorrectable), .scrub_uncorr_cnt(scrub_uncorr_cnt)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [DATA_W-1:0] d);
        req_valid = 1'b1; req_write = 1'b1;
        req_addr = ADDR_W'(a); req_wdata = d;
        model[a] = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic flip(input int a, input int pos);
        u0.u_store.mem[a][pos] = ~u0.u_store.mem[a][pos];
    endtask

    // Read and check data and, if asked, the flags.
    task automatic rd_check(input int a, input logic [DATA_W-1:0] exp_d,
                            input bit chk_flags, input bit exp_c, input bit exp_u,
                            input string req);
        req_valid = 1'b1; req_write = 1'b0; req_addr = ADDR_W'(a);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check(rsp_valid == 1'b1, req, "rsp_valid", 64'(rsp_valid), 64'd1);
        check(rsp_rdata == exp_d && !rsp_uncorrectable || chk_flags, req, "rdata",
              64'(rsp_rdata), 64'(exp_d));
        if (chk_flags) begin
            check(rsp_rdata == exp_d, req, "rdata", 64'(rsp_rdata), 64'(exp_d));
            check(rsp_corrected == exp_c && rsp_uncorrectable == exp_u, req, "flags c/u",
                  {62'd0, rsp_corrected, rsp_uncorrectable}, {62'd0, exp_c, exp_u});
        end
    endtask

    bit done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] d;
        logic [CNT_W-1:0]  c0;
        int a, b, p, q;
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        req_valid = 1'b1; req_write = 1'b1; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(rsp_valid == 1'b0, "R1", "reset rsp_valid", 64'(rsp_valid), 64'd0);
        check(scrub_uncorr_cnt == '0, "R9", "reset count", 64'(scrub_uncorr_cnt), 64'd0);
        rst_n = 1'b1;
        // Back-to-back init writes keep the scrubber parked at address 0.
        for (int i = 0; i < DEPTH; i++) begin
            req_valid = 1'b1; req_write = 1'b1;
            req_addr = ADDR_W'(i);
            model[i] = $urandom;
            req_wdata = model[i];
            @(negedge clk);
        end
        req_valid = 1'b0;

        // R10: scrub reads addr 2 on idle edge 5, checks on edge 6; user write lands on edge 6.
        flip(2, b_pos(3));
        idle(5);
        wr(2, 32'hC0DE_0002);
        idle(4);
        rd_check(2, 32'hC0DE_0002, 1'b1, 1'b0, 1'b0, "R10");

        // R1 latency and no response for writes
        wr(9, 32'h1234_5678);
        idle(2);
        check(rsp_valid == 1'b0, "R1", "write gives no rsp", 64'(rsp_valid), 64'd0);
        req_valid = 1'b1; req_write = 1'b0; req_addr = ADDR_W'(9);
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid == 1'b0, "R1", "rsp_valid after first edge", 64'(rsp_valid), 64'd0);
        @(negedge clk);
        check(rsp_valid == 1'b1 && rsp_rdata == 32'h1234_5678, "R1", "rsp after second edge",
              64'(rsp_rdata), 64'h1234_5678);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1", "rsp one cycle", 64'(rsp_valid), 64'd0);

        // R2: single data-bit flips
        for (int t = 0; t < 8; t++) begin
            a = $urandom_range(0, DEPTH - 1);
            d = $urandom;
            wr(a, d);
            flip(a, b_pos($urandom_range(0, DATA_W - 1)));
            rd_check(a, d, 1'b1, 1'b1, 1'b0, "R2");
        end

        // R3: every check-bit position
        for (int j = 0; j < CHK; j++) begin
            d = $urandom;
            wr(4, d);
            flip(4, 2 ** j);
            rd_check(4, d, 1'b1, 1'b1, 1'b0, "R3");
        end

        // R4: overall parity bit only
        for (int t = 0; t < 2; t++) begin
            d = $urandom;
            wr(6, d);
            flip(6, 0);
            rd_check(6, d, 1'b1, 1'b1, 1'b0, "R4");
        end

        // R5: two distinct positions, data returned as stored
        for (int t = 0; t < 6; t++) begin
            a = $urandom_range(0, DEPTH - 1);
            d = $urandom;
            wr(a, d);
            p = (t == 0) ? 0 : $urandom_range(0, NPOS);
            q = $urandom_range(1, NPOS);
            if (q == p) q = (q == NPOS) ? 1 : q + 1;
            flip(a, p);
            flip(a, q);
            if (b_idx(p) >= 0) d[b_idx(p)] = ~d[b_idx(p)];
            if (b_idx(q) >= 0) d[b_idx(q)] = ~d[b_idx(q)];
            rd_check(a, d, 1'b1, 1'b0, 1'b1, "R5");
            wr(a, model[a]);
        end

        // R8: a lone upset is repaired by the idle scrub; a later second upset stays single
        d = $urandom;
        wr(5, d);
        flip(5, b_pos(1));
        idle(4 * DEPTH + 8);
        flip(5, b_pos(20));
        rd_check(5, d, 1'b1, 1'b1, 1'b0, "R8");

        // R9: double-error word is counted and left as stored
        idle(3 * DEPTH);
        c0 = scrub_uncorr_cnt;
        d = $urandom;
        wr(7, d);
        flip(7, b_pos(2));
        flip(7, b_pos(30));
        idle(2 * DEPTH + 8);
        check(scrub_uncorr_cnt > c0, "R9", "count rises", 64'(scrub_uncorr_cnt), 64'(c0 + 1));
        rd_check(7, d ^ 32'h4000_0004, 1'b1, 1'b0, 1'b1, "R9");
        wr(7, d);
        idle(4);
        c0 = scrub_uncorr_cnt;
        idle(3 * DEPTH);
        check(scrub_uncorr_cnt == c0, "R9", "clean words leave count", 64'(scrub_uncorr_cnt), 64'(c0));

        // R7: random traffic with single upsets injected after writes
        for (int t = 0; t < 400; t++) begin
            a = $urandom_range(0, DEPTH - 1);
            b = $urandom_range(0, 9);
            if (b < 4) begin
                wr(a, $urandom);
                if ($urandom_range(0, 2) == 0) flip(a, $urandom_range(0, NPOS));
            end else begin
                rd_check(a, model[a], 1'b0, 1'b0, 1'b0, "R7");
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule